// File: doc/BRIEF.md
# Dual-Edge Timestamp Latch Unit

The unit takes a time stamp of a free-running 64-bit system time value whenever an external, asynchronous latch signal changes level. A rising level change and a falling level change each have their own 64-bit capture register and their own event flag. The latch signal is brought into the clock domain by a two-flop synchronizer. The synchronized signal is then compared with its previous value to find each edge.

Two independent byte-wide access ports read the captures: one on the network side and one on the local host side. A read of the low byte of a capture register returns that byte. The same read freezes the remaining upper bytes in a private snapshot that belongs to that port and that register. Later reads of the upper bytes come from this snapshot, so a byte-by-byte read gives one coherent time value even if a new capture arrives in the middle of it.

Event flags clear when a low-byte access is made. Two configuration inputs choose which port and which access type acknowledges the flag. A new capture always takes priority over a clear that arrives in the same cycle.

Top module: `ts_latch_unit`

## Requirements
- R1: After reset both capture registers read 0 on every byte of both ports, both read data outputs are 0, and `evt_status` is 2'b00.
- R2: When `latch_in` is first sampled high at clock edge k (after being low), the rising capture (edge select 0) holds the `sys_time` value sampled at edge k+2, and `evt_status[0]` is set after that edge.
- R3: When `latch_in` is first sampled low at clock edge k (after being high), the falling capture (edge select 1) holds the `sys_time` value sampled at edge k+2, and `evt_status[1]` is set after that edge.
- R4: A read with byte offset 0 returns capture bits 7:0 and snapshots bits 63:8 of the selected register for that port only. A read with byte offset n (1..7) returns snapshot bits 8n+7:8n, even when the capture has changed since the offset-0 read.
- R5: The two ports have separate snapshots. An offset-0 read on one port never changes what the other port returns for offsets 1..7.
- R6: Write strobes on either port never change any capture register.
- R7: With `cfg_host_owns`=0, a network read at offset 0 clears the status bit of the selected register. No other access clears a status bit.
- R8: With `cfg_host_owns`=1 and `cfg_host_wr_ack`=0, a host read at offset 0 clears the selected status bit. Network accesses and host writes leave the status unchanged.
- R9: With `cfg_host_owns`=1 and `cfg_host_wr_ack`=1, a host write at offset 0 clears the selected status bit. Host reads and network accesses leave the status unchanged.
- R10: When a capture and a clear of the same status bit occur on the same clock edge, the status bit stays set.
- R11: The read data of a port is registered. It shows the byte one clock after the read strobe is sampled and holds its value while that port's read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| sys_time | input | 64 | Free-running system time value |
| latch_in | input | 1 | Asynchronous latch signal |
| cfg_host_owns | input | 1 | 0: network reads acknowledge events; 1: host acknowledges |
| cfg_host_wr_ack | input | 1 | With host ownership, 1 selects acknowledge by host write instead of read |
| net_rd | input | 1 | Network-side read strobe |
| net_wr | input | 1 | Network-side write strobe (data discarded) |
| net_edge | input | 1 | Network register select: 0 rising capture, 1 falling capture |
| net_byte | input | 3 | Network byte offset 0..7 |
| net_rdata | output | 8 | Network read data, registered |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (data discarded) |
| host_edge | input | 1 | Host register select: 0 rising capture, 1 falling capture |
| host_byte | input | 3 | Host byte offset 0..7 |
| host_rdata | output | 8 | Host read data, registered |
| evt_status | output | 2 | Bit 0 rising event pending, bit 1 falling event pending |

## Verification
The hardest case to reach is a clear landing on exactly the clock edge where a new capture is written. The latch change and the low-byte read must be placed three edges apart, counting both synchronizer flops and the edge-history flop. The bench drives `sys_time` from a cycle counter, changes the latch on a known negative edge, and raises the read strobe two negative edges later so that both events meet on one rising edge. Snapshot coherence is tested in a similar way: a new capture is forced between the low-byte read and the upper-byte reads, on one port and then interleaved across both ports.

// File: rtl/ts_latch_pkg.sv
package ts_latch_pkg;
  localparam int unsigned TS_NEDGE     = 2;
  localparam int unsigned TS_EDGE_RISE = 0;
  localparam int unsigned TS_EDGE_FALL = 1;

  typedef enum logic [1:0] {
    ACK_NET_READ   = 2'd0,
    ACK_HOST_READ  = 2'd1,
    ACK_HOST_WRITE = 2'd2
  } ack_src_e;
endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_o
);
  logic [1:0] rs_q;
  logic [1:0] rs_d;

  always_comb begin
    rs_d = {rs_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= rs_d;
    end
  end

  assign rst_n_o = rs_q[1];
endmodule

// File: rtl/ts_sync_edge.sv
module ts_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);
  // stages 0..SYNC_STAGES-1 synchronize, stage SYNC_STAGES holds history
  logic [SYNC_STAGES:0] pipe_q;
  logic [SYNC_STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[SYNC_STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
  assign fall_o = ~pipe_q[SYNC_STAGES-1] & pipe_q[SYNC_STAGES];

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R3
endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned NEDGE  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TIME_W-1:0]             sys_time,
  input  logic [NEDGE-1:0]              evt,
  input  logic [NEDGE-1:0]              clr,
  output logic [NEDGE-1:0][TIME_W-1:0]  cap_o,
  output logic [NEDGE-1:0]              status_o
);
  logic [NEDGE-1:0][TIME_W-1:0] cap_q;
  logic [NEDGE-1:0]             st_q;
  logic [NEDGE-1:0]             st_d;

  for (genvar g = 0; g < NEDGE; g++) begin : g_edge
    // capture register with explicit clock enable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q[g] <= '0;
      end else if (evt[g]) begin
        cap_q[g] <= sys_time;
      end
    end

    // set wins over clear
    always_comb begin
      if (evt[g]) begin
        st_d[g] = 1'b1;
      end else if (clr[g]) begin
        st_d[g] = 1'b0;
      end else begin
        st_d[g] = st_q[g];
      end
    end

    AST_CAPTURE_TAKES_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> (cap_q[g] == $past(sys_time))); // R2
    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !evt[g] |=> $stable(cap_q[g])); // R6
    AST_STATUS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> st_q[g]); // R10
    AST_STATUS_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !evt[g]) |=> !st_q[g]); // R7
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign cap_o    = cap_q;
  assign status_o = st_q;
endmodule

// File: rtl/ts_read_port.sv
module ts_read_port #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NEDGE  = 2,
  localparam int unsigned NBYTE  = TIME_W / BYTE_W,
  localparam int unsigned BIDX_W = $clog2(NBYTE),
  localparam int unsigned ESEL_W = $clog2(NEDGE),
  localparam int unsigned SHD_W  = TIME_W - BYTE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd,
  input  logic [ESEL_W-1:0]             edge_sel,
  input  logic [BIDX_W-1:0]             byte_idx,
  input  logic [NEDGE-1:0][TIME_W-1:0]  cap,
  output logic [BYTE_W-1:0]             rdata_o
);
  logic [NEDGE-1:0][SHD_W-1:0] shd_q;
  logic [NEDGE-1:0]            shd_en;
  logic                        low_rd;
  logic [TIME_W-1:0]           sel_cap;
  logic [TIME_W-1:0]           view;
  logic [BYTE_W-1:0]           rdata_q;
  logic [BYTE_W-1:0]           rdata_d;

  assign low_rd = rd && (byte_idx == '0);

  for (genvar g = 0; g < NEDGE; g++) begin : g_shadow
    assign shd_en[g] = low_rd && (edge_sel == ESEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q[g] <= '0;
      end else if (shd_en[g]) begin
        shd_q[g] <= cap[g][TIME_W-1:BYTE_W];
      end
    end

    AST_SNAPSHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !shd_en[g] |=> $stable(shd_q[g])); // R4
  end

  always_comb begin
    sel_cap = cap[edge_sel];
    view    = {shd_q[edge_sel], sel_cap[BYTE_W-1:0]};
    if (rd) begin
      rdata_d = view[int'(byte_idx)*BYTE_W +: BYTE_W];
    end else begin
      rdata_d = rdata_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q)); // R11
  AST_LOW_BYTE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd |=> (rdata_q == $past(sel_cap[BYTE_W-1:0]))); // R4
endmodule

// File: rtl/ts_latch_unit.sv
module ts_latch_unit
  import ts_latch_pkg::*;
#(
  parameter int unsigned TIME_W      = 64,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NBYTE  = TIME_W / BYTE_W,
  localparam int unsigned BIDX_W = $clog2(NBYTE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              latch_in,
  input  logic              cfg_host_owns,
  input  logic              cfg_host_wr_ack,
  input  logic              net_rd,
  input  logic              net_wr,
  input  logic              net_edge,
  input  logic [BIDX_W-1:0] net_byte,
  output logic [BYTE_W-1:0] net_rdata,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_edge,
  input  logic [BIDX_W-1:0] host_byte,
  output logic [BYTE_W-1:0] host_rdata,
  output logic [TS_NEDGE-1:0] evt_status
);
  logic                               rst_sync_n;
  logic                               rise;
  logic                               fall;
  logic [TS_NEDGE-1:0]                evt;
  logic [TS_NEDGE-1:0]                clr;
  logic [TS_NEDGE-1:0][TIME_W-1:0]    cap;
  ack_src_e                           ack_src;

  ts_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_o     (rst_sync_n)
  );

  ts_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (latch_in),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  always_comb begin
    evt               = '0;
    evt[TS_EDGE_RISE] = rise;
    evt[TS_EDGE_FALL] = fall;
  end

  // which access acknowledges an event
  always_comb begin
    if (!cfg_host_owns) begin
      ack_src = ACK_NET_READ;
    end else if (cfg_host_wr_ack) begin
      ack_src = ACK_HOST_WRITE;
    end else begin
      ack_src = ACK_HOST_READ;
    end
  end

  always_comb begin
    for (int e = 0; e < int'(TS_NEDGE); e++) begin
      unique case (ack_src)
        ACK_NET_READ:   clr[e] = net_rd && (net_byte == '0) && (net_edge == e[0]);
        ACK_HOST_READ:  clr[e] = host_rd && (host_byte == '0) && (host_edge == e[0]);
        ACK_HOST_WRITE: clr[e] = host_wr && (host_byte == '0) && (host_edge == e[0]);
        default:        clr[e] = 1'b0;
      endcase
    end
  end

  ts_capture #(.TIME_W(TIME_W), .NEDGE(TS_NEDGE)) u_capture (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sys_time (sys_time),
    .evt      (evt),
    .clr      (clr),
    .cap_o    (cap),
    .status_o (evt_status)
  );

  ts_read_port #(.TIME_W(TIME_W), .BYTE_W(BYTE_W), .NEDGE(TS_NEDGE)) u_net_port (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd       (net_rd),
    .edge_sel (net_edge),
    .byte_idx (net_byte),
    .cap      (cap),
    .rdata_o  (net_rdata)
  );

  ts_read_port #(.TIME_W(TIME_W), .BYTE_W(BYTE_W), .NEDGE(TS_NEDGE)) u_host_port (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd       (host_rd),
    .edge_sel (host_edge),
    .byte_idx (host_byte),
    .cap      (cap),
    .rdata_o  (host_rdata)
  );

  AST_NO_ACK_OFF_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((net_byte != '0) && (host_byte != '0)) |=> ((~evt_status & $past(evt_status)) == '0)); // R7
  AST_NET_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (net_wr && !net_rd) |=> $stable(net_rdata)); // R6
  AST_HOST_SILENT_WHEN_NET_OWNS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_host_owns && !net_rd) |=> ((~evt_status & $past(evt_status)) == '0)); // R8
endmodule

// File: tb/ts_latch_unit_tb_top.sv
module ts_latch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_time;
  logic        latch_in;
  logic        cfg_host_owns, cfg_host_wr_ack;
  logic        net_rd, net_wr, net_edge;
  logic [2:0]  net_byte;
  logic [7:0]  net_rdata;
  logic        host_rd, host_wr, host_edge;
  logic [2:0]  host_byte;
  logic [7:0]  host_rdata;
  logic [1:0]  evt_status;

  int nchk = 0;
  int nerr = 0;
  int ncyc = 0;
  logic [63:0] exp_cap [2];

  always #10 clk = ~clk;

  ts_latch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .latch_in(latch_in),
    .cfg_host_owns(cfg_host_owns), .cfg_host_wr_ack(cfg_host_wr_ack),
    .net_rd(net_rd), .net_wr(net_wr), .net_edge(net_edge), .net_byte(net_byte),
    .net_rdata(net_rdata), .host_rd(host_rd), .host_wr(host_wr),
    .host_edge(host_edge), .host_byte(host_byte), .host_rdata(host_rdata),
    .evt_status(evt_status)
  );

  function automatic logic [63:0] tval(int c);
    logic [31:0] u;
    u = c;
    return {u * 32'h9E3779B1, ~u};
  endfunction

  initial begin
    sys_time = tval(0);
    forever begin
      @(posedge clk);
      #3;
      ncyc = ncyc + 1;
      sys_time = tval(ncyc);
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic acc(bit host, bit wr, bit e, int b, output logic [7:0] d);
    @(negedge clk);
    if (host) begin
      host_rd = !wr; host_wr = wr; host_edge = e; host_byte = 3'(b);
    end else begin
      net_rd = !wr; net_wr = wr; net_edge = e; net_byte = 3'(b);
    end
    @(negedge clk);
    host_rd = 0; host_wr = 0; net_rd = 0; net_wr = 0;
    d = host ? host_rdata : net_rdata;
  endtask

  task automatic read64(bit host, bit e, output logic [63:0] v);
    logic [7:0] d;
    for (int b = 0; b < 8; b++) begin
      acc(host, 0, e, b, d);
      v[8*b +: 8] = d;
    end
  endtask

  // latch change: capture value is system time two counts after the change
  task automatic set_latch(bit v);
    @(negedge clk);
    latch_in = v;
    exp_cap[v ? 0 : 1] = tval(ncyc + 2);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #(20 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [7:0]  d;
    logic [63:0] snap_a, snap_b;
    logic [7:0]  hold;
    rst_n = 0; latch_in = 0; cfg_host_owns = 0; cfg_host_wr_ack = 0;
    net_rd = 0; net_wr = 0; net_edge = 0; net_byte = 0;
    host_rd = 0; host_wr = 0; host_edge = 0; host_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 status", 64'(evt_status), 0);
    chk("R1 net_rdata", 64'(net_rdata), 0);
    chk("R1 host_rdata", 64'(host_rdata), 0);
    for (int e = 0; e < 2; e++) begin
      read64(0, e[0], v); chk("R1 net capture", v, 0);
      read64(1, e[0], v); chk("R1 host capture", v, 0);
    end

    // R2 / R3 several captures on both edges, read through both ports
    cfg_host_owns = 1; cfg_host_wr_ack = 1;
    for (int i = 0; i < 3; i++) begin
      set_latch(1);
      chk("R2 status rise", 64'(evt_status[0]), 1);
      read64(0, 0, v); chk("R2 rise capture net", v, exp_cap[0]);
      read64(1, 0, v); chk("R2 rise capture host", v, exp_cap[0]);
      set_latch(0);
      chk("R3 status fall", 64'(evt_status[1]), 1);
      read64(0, 1, v); chk("R3 fall capture net", v, exp_cap[1]);
      read64(1, 1, v); chk("R3 fall capture host", v, exp_cap[1]);
      repeat (i) @(negedge clk);
    end

    // R4 snapshot coherence across a new capture
    snap_a = exp_cap[0];
    acc(0, 0, 0, 0, d);
    chk("R4 low byte", 64'(d), 64'(snap_a[7:0]));
    set_latch(1); set_latch(0);
    for (int b = 1; b < 8; b++) begin
      acc(0, 0, 0, b, d);
      chk("R4 upper from snapshot", 64'(d), 64'(snap_a[8*b +: 8]));
    end
    read64(0, 0, v); chk("R4 fresh read", v, exp_cap[0]);

    // R5 independent snapshots
    snap_b = exp_cap[0];
    acc(1, 0, 0, 0, d);
    set_latch(1); set_latch(0);
    acc(0, 0, 0, 0, d);
    chk("R5 net low new", 64'(d), 64'(exp_cap[0][7:0]));
    for (int b = 1; b < 8; b++) begin
      acc(1, 0, 0, b, d);
      chk("R5 host keeps its snapshot", 64'(d), 64'(snap_b[8*b +: 8]));
      acc(0, 0, 0, b, d);
      chk("R5 net has its snapshot", 64'(d), 64'(exp_cap[0][8*b +: 8]));
    end

    // R6 writes from both ports to every byte of both registers
    cfg_host_owns = 0;
    for (int p = 0; p < 2; p++)
      for (int e = 0; e < 2; e++)
        for (int b = 0; b < 8; b++)
          acc(p[0], 1, e[0], b, d);
    for (int e = 0; e < 2; e++) begin
      read64(0, e[0], v); chk("R6 capture unchanged", v, exp_cap[e]);
    end

    // R11 read data holds without a read strobe
    acc(1, 0, 1, 3, d);
    hold = host_rdata;
    chk("R11 one-cycle latency", 64'(hold), 64'(exp_cap[1][31:24]));
    @(negedge clk); host_wr = 1; net_rd = 1; net_byte = 0;
    repeat (3) @(negedge clk);
    host_wr = 0; net_rd = 0;
    chk("R11 host rdata held", 64'(host_rdata), 64'(hold));

    // R7 / R8 / R9 acknowledge sweep: mode x port x op x edge x offset
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 2; p++)
        for (int op = 0; op < 2; op++)
          for (int e = 0; e < 2; e++)
            for (int bi = 0; bi < 2; bi++) begin
              bit clr;
              logic [1:0] expst;
              string tag;
              cfg_host_owns = (m != 0); cfg_host_wr_ack = (m == 2);
              if (evt_status != 2'b11) begin
                set_latch(1); set_latch(0);
              end
              acc(p[0], op[0], e[0], bi * 5, d);
              @(negedge clk);
              clr = (bi == 0) &&
                    ((m == 0 && p == 0 && op == 0) ||
                     (m == 1 && p == 1 && op == 0) ||
                     (m == 2 && p == 1 && op == 1));
              expst = 2'b11;
              if (clr) expst[e] = 1'b0;
              tag = (m == 0) ? "R7 ack sweep" : (m == 1) ? "R8 ack sweep" : "R9 ack sweep";
              chk(tag, 64'(evt_status), 64'(expst));
            end

    // R10 capture and acknowledge on the same edge
    cfg_host_owns = 0; cfg_host_wr_ack = 0;
    acc(0, 0, 0, 0, d); acc(0, 0, 1, 0, d);
    chk("R10 precondition cleared", 64'(evt_status), 0);
    snap_a = exp_cap[0];
    @(negedge clk);
    latch_in = 1;
    exp_cap[0] = tval(ncyc + 2);
    @(negedge clk);
    @(negedge clk);
    net_rd = 1; net_edge = 0; net_byte = 0;
    @(negedge clk);
    net_rd = 0;
    chk("R10 old low byte returned", 64'(net_rdata), 64'(snap_a[7:0]));
    chk("R10 status stays set", 64'(evt_status[0]), 1);
    repeat (2) @(negedge clk);
    read64(1, 0, v); chk("R10 new capture", v, exp_cap[0]);

    summary();
    $finish;
  end
endmodule